// File: doc/BRIEF.md
# Coherence invalidation classifier

This block is a passive monitor that sits beside one cache level of a processor in a shared-memory multiprocessor. It watches three inputs. The first is the local access stream, which carries the line, the word within the line, a hit flag from the cache and a flag for accesses made while holding a lock. The second is the stream of snooped invalidations caused by remote writes, each carrying the line and the word that was written. The third is a one-cycle pulse marking a synchronization point. The monitor keeps a small direct-mapped table of recently touched lines. For each line it records which words were touched locally, whether the most recent local access fell in the current region, and whether that access was lock-protected.

Each invalidation of a tracked line is sorted along two axes. The first is true or false sharing, decided by word overlap with the locally touched words. The second is in-region or across-region, decided by whether a synchronization pulse came between the last local access and the invalidation. The invalidated line is then marked as lost. The first later miss on a lost line is counted as a coherence miss and is linked back to the kind of invalidation that caused it. Every count is a saturating counter that software-side tooling reads through a combinational register port.

Top module: `coh_inv_classifier`

## Requirements
- R1: After reset every counter reads 0. Read addresses map to counters as follows: 0 misses, 1 coherence misses, 2 in-region true sharing with an unlocked last access, 3 in-region true sharing with a locked last access, 4 across-region true sharing, 5 in-region false sharing, 6 across-region false sharing, 7 true-sharing invalidations followed by a miss, 8 false-sharing invalidations followed by a miss. Addresses 9 to 15 read 0.
- R2: An invalidation of a tracked, not-lost line whose word is in the line's touched mask is true sharing. The mask accumulates every word accessed locally since the line was allocated or refilled.
- R3: An invalidation of a tracked, not-lost line whose word is not in the touched mask is false sharing. It counts at address 5 when in-region and at address 6 when across-region.
- R4: An invalidation is in-region when no sync pulse arrived after the line's most recent local access. Otherwise it is across-region (true sharing counts at address 4).
- R5: In-region true sharing counts at address 3 when the line's most recent local access had the lock flag set, and at address 2 otherwise.
- R6: An invalidation of an untracked line, or of a line already marked lost, changes no counter.
- R7: Every valid local access with the hit flag low increments the miss counter.
- R8: The first miss to a lost line increments the coherence-miss counter and the link counter (7 or 8) of that invalidation's kind. It then clears the lost mark, so a further miss counts only at address 0.
- R9: A hit to a lost line clears the lost mark without counting a coherence miss or a link.
- R10: An access to a line whose table slot holds a different line replaces that slot and discards the old line's lost mark.
- R11: Every counter saturates at its all-ones value.
- R12: A high clear input zeroes every counter at the next edge, taking precedence over any increment in that cycle.
- R13: Within one cycle, an invalidation is applied before a local access to the same line, and a local access made in the same cycle as a sync pulse belongs to the region that the pulse closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all counters |
| acc_valid | input | 1 | Local access present this cycle |
| acc_line | input | LINE_W | Line address of the local access |
| acc_word | input | log2(WORDS) | Word within the line |
| acc_hit | input | 1 | Cache reported a hit |
| acc_locked | input | 1 | Access made inside a lock-protected section |
| inv_valid | input | 1 | Snooped invalidation present this cycle |
| inv_line | input | LINE_W | Line address being invalidated |
| inv_word | input | log2(WORDS) | Word written by the remote processor |
| sync_pulse | input | 1 | Synchronization point reached |
| rd_addr | input | 4 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The assertions assume that at most one invalidation and one local access arrive per cycle. They also assume that the word index lies inside the line, which the power-of-two WORDS parameter makes automatic. The linkage property further assumes that nothing other than the monitored invalidation changes a line between an invalidation and the next access. The bench meets these assumptions by driving single, isolated operations separated by idle cycles, except in the deliberate same-cycle cases of R13. A near-exhaustive sweep covers every pair of touched word and written word, with and without an intervening sync pulse and with the lock flag high and low. The counters are cleared before each case, so every expected count follows arithmetically from that case alone.

// File: rtl/coh_cls_pkg.sv
package coh_cls_pkg;

    localparam int NUM_CNT = 9;

    typedef enum logic [3:0] {
        CNT_MISS          = 4'd0,
        CNT_COH_MISS      = 4'd1,
        CNT_INR_TRUE_OPEN = 4'd2,
        CNT_INR_TRUE_LOCK = 4'd3,
        CNT_XR_TRUE       = 4'd4,
        CNT_INR_FALSE     = 4'd5,
        CNT_XR_FALSE      = 4'd6,
        CNT_LINK_TRUE     = 4'd7,
        CNT_LINK_FALSE    = 4'd8
    } cnt_sel_e;

endpackage

// File: rtl/coh_sat_cnt.sv
module coh_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.cnt;

    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q) == CNT_MAX && !$past(clr)) |-> q == CNT_MAX);

    assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (q == $past(q) || q == $past(q) + 1'b1));

    assert_clear_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> q == '0);

endmodule

// File: rtl/coh_line_tracker.sv
module coh_line_tracker
    import coh_cls_pkg::*;
#(
    parameter int LINE_W  = 16,
    parameter int ENTRIES = 16,
    parameter int WORDS   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = LINE_W - IDX_W,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [LINE_W-1:0]  acc_line,
    input  logic [WIDX_W-1:0]  acc_word,
    input  logic               acc_hit,
    input  logic               acc_locked,
    input  logic               inv_valid,
    input  logic [LINE_W-1:0]  inv_line,
    input  logic [WIDX_W-1:0]  inv_word,
    input  logic               sync_pulse,
    output logic [NUM_CNT-1:0] ev
);

    typedef struct packed {
        logic             vld;
        logic             lost;
        logic             lost_true;
        logic             inreg;
        logic             lockd;
        logic [WORDS-1:0] mask;
        logic [TAG_W-1:0] tag;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [IDX_W-1:0] acc_idx, inv_idx;
    logic [TAG_W-1:0] acc_tag, inv_tag;
    entry_t           inv_e, acc_e;
    logic             inv_hit_line, inv_true;

    assign acc_idx = acc_line[IDX_W-1:0];
    assign acc_tag = acc_line[LINE_W-1:IDX_W];
    assign inv_idx = inv_line[IDX_W-1:0];
    assign inv_tag = inv_line[LINE_W-1:IDX_W];

    always_comb begin
        st_d         = st_q;
        ev           = '0;
        inv_e        = st_q.tbl[inv_idx];
        inv_hit_line = inv_e.vld && !inv_e.lost && (inv_e.tag == inv_tag);
        inv_true     = inv_e.mask[inv_word];

        // remote invalidation is applied first
        if (inv_valid && inv_hit_line) begin
            if (inv_true) begin
                if (inv_e.inreg) begin
                    ev[inv_e.lockd ? CNT_INR_TRUE_LOCK : CNT_INR_TRUE_OPEN] = 1'b1;
                end else begin
                    ev[CNT_XR_TRUE] = 1'b1;
                end
            end else begin
                ev[inv_e.inreg ? CNT_INR_FALSE : CNT_XR_FALSE] = 1'b1;
            end
            inv_e.lost      = 1'b1;
            inv_e.lost_true = inv_true;
            inv_e.mask      = '0;
            inv_e.inreg     = 1'b0;
            st_d.tbl[inv_idx] = inv_e;
        end

        // local access sees the post-invalidation state
        acc_e = st_d.tbl[acc_idx];
        if (acc_valid) begin
            if (!acc_hit) begin
                ev[CNT_MISS] = 1'b1;
            end
            if (acc_e.vld && acc_e.tag == acc_tag) begin
                if (acc_e.lost) begin
                    if (!acc_hit) begin
                        ev[CNT_COH_MISS] = 1'b1;
                        ev[acc_e.lost_true ? CNT_LINK_TRUE : CNT_LINK_FALSE] = 1'b1;
                    end
                    acc_e.lost = 1'b0;
                    acc_e.mask = '0;
                end
            end else begin
                acc_e     = '0;
                acc_e.vld = 1'b1;
                acc_e.tag = acc_tag;
            end
            acc_e.mask[acc_word] = 1'b1;
            acc_e.inreg          = 1'b1;
            acc_e.lockd          = acc_locked;
            st_d.tbl[acc_idx]    = acc_e;
        end

        // a sync pulse closes the region after this cycle's events
        if (sync_pulse) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.tbl[i].inreg = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_coh_is_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev[CNT_COH_MISS] |-> ev[CNT_MISS]);

    assert_one_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ev[CNT_LINK_FALSE:CNT_LINK_TRUE]) == (ev[CNT_COH_MISS] ? 1 : 0));

    assert_one_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev[CNT_XR_FALSE:CNT_INR_TRUE_OPEN]));

    assert_inv_then_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(|ev[CNT_XR_FALSE:CNT_INR_TRUE_OPEN]) && !$past(acc_valid)
         && acc_valid && !acc_hit && !inv_valid && acc_line == $past(inv_line))
        |-> ev[CNT_COH_MISS]);

endmodule

// File: rtl/coh_inv_classifier.sv
module coh_inv_classifier
    import coh_cls_pkg::*;
#(
    parameter int LINE_W  = 16,
    parameter int ENTRIES = 16,
    parameter int WORDS   = 8,
    parameter int CNT_W   = 32,
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [WIDX_W-1:0] acc_word,
    input  logic              acc_hit,
    input  logic              acc_locked,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line,
    input  logic [WIDX_W-1:0] inv_word,
    input  logic              sync_pulse,
    input  logic [3:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data
);

    logic [NUM_CNT-1:0] ev;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    coh_line_tracker #(
        .LINE_W (LINE_W),
        .ENTRIES(ENTRIES),
        .WORDS  (WORDS)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_line  (acc_line),
        .acc_word  (acc_word),
        .acc_hit   (acc_hit),
        .acc_locked(acc_locked),
        .inv_valid (inv_valid),
        .inv_line  (inv_line),
        .inv_word  (inv_word),
        .sync_pulse(sync_pulse),
        .ev        (ev)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        coh_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .inc  (ev[g]),
            .q    (cnt_val[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_CNT) begin
            rd_data = cnt_val[rd_addr];
        end
    end

    assert_miss_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_valid) && !$past(acc_hit) && !$past(clr)
         && $past(cnt_val[0]) != {CNT_W{1'b1}})
        |-> cnt_val[0] == $past(cnt_val[0]) + 1'b1);

endmodule

// File: tb/sim_coh_inv_classifier.sv
module sim_coh_inv_classifier;

    localparam int LW = 6;
    localparam int NE = 4;
    localparam int NW = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          acc_valid = 1'b0;
    logic [LW-1:0] acc_line = '0;
    logic [1:0]    acc_word = '0;
    logic          acc_hit = 1'b0;
    logic          acc_locked = 1'b0;
    logic          inv_valid = 1'b0;
    logic [LW-1:0] inv_line = '0;
    logic [1:0]    inv_word = '0;
    logic          sync_pulse = 1'b0;
    logic [3:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    coh_inv_classifier #(.LINE_W(LW), .ENTRIES(NE), .WORDS(NW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .acc_valid(acc_valid), .acc_line(acc_line), .acc_word(acc_word),
        .acc_hit(acc_hit), .acc_locked(acc_locked),
        .inv_valid(inv_valid), .inv_line(inv_line), .inv_word(inv_word),
        .sync_pulse(sync_pulse), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic drive(input int av, input int al, input int aw, input int ah, input int alk,
                         input int iv, input int il, input int iw, input int sp, input int cl);
        @(negedge clk);
        acc_valid  = av[0];  acc_line = LW'(al); acc_word = 2'(aw);
        acc_hit    = ah[0];  acc_locked = alk[0];
        inv_valid  = iv[0];  inv_line = LW'(il); inv_word = 2'(iw);
        sync_pulse = sp[0];  clr = cl[0];
        @(negedge clk);
        acc_valid = 1'b0; inv_valid = 1'b0; sync_pulse = 1'b0; clr = 1'b0;
    endtask

    task automatic acc(input int l, input int w, input int hit, input int lk);
        drive(1, l, w, hit, lk, 0, 0, 0, 0, 0);
    endtask

    task automatic inv(input int l, input int w);
        drive(0, 0, 0, 0, 0, 1, l, w, 0, 0);
    endtask

    task automatic do_sync();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic do_clear();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic chk(input int idx, input int exp, input string tag);
        rd_addr = 4'(idx);
        #1;
        n_tests++;
        if (int'(rd_data) != exp) begin
            n_fail++;
            $display("FAIL %s counter %0d actual %0d expected %0d", tag, idx, rd_data, exp);
        end
    endtask

    task automatic chk_all(input int e [9], input string tag);
        for (int i = 0; i < 9; i++) chk(i, e[i], tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int e [9];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and unmapped addresses
        for (int i = 0; i < 16; i++) chk(i, 0, "R1");

        // R2 R3 R4 R5 R8: sweep touched word x written word x sync x lock
        for (int s = 0; s < 64; s++) begin
            int wt, wi, sy, lk, tr;
            wt = s & 3; wi = (s >> 2) & 3; sy = (s >> 4) & 1; lk = (s >> 5) & 1;
            tr = (wt == wi) ? 1 : 0;
            do_clear();
            acc(s, wt, 0, lk);
            if (sy != 0) do_sync();
            inv(s, wi);
            acc(s, wi, 0, 0);
            e[0] = 2; e[1] = 1;
            e[2] = (tr == 1 && sy == 0 && lk == 0) ? 1 : 0;  // R5
            e[3] = (tr == 1 && sy == 0 && lk == 1) ? 1 : 0;  // R5
            e[4] = (tr == 1 && sy == 1) ? 1 : 0;             // R4
            e[5] = (tr == 0 && sy == 0) ? 1 : 0;             // R3
            e[6] = (tr == 0 && sy == 1) ? 1 : 0;             // R3
            e[7] = tr;                                        // R8
            e[8] = 1 - tr;
            chk_all(e, tr == 1 ? "R2/R4/R5/R8 sweep" : "R3/R4/R8 sweep");
        end

        // R6: untracked and already-lost invalidations ignored
        do_clear();
        inv(5, 0);
        e = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
        chk_all(e, "R6 untracked");
        acc(5, 0, 0, 0);
        inv(5, 1);
        inv(5, 0);
        e = '{1, 0, 0, 0, 0, 1, 0, 0, 0};
        chk_all(e, "R6 already lost");

        // R9: hit on lost line clears mark silently
        acc(5, 0, 1, 0);
        acc(5, 0, 0, 0);
        e = '{2, 0, 0, 0, 0, 1, 0, 0, 0};
        chk_all(e, "R9");

        // R10: slot conflict discards lost mark (lines 1 and 5 share slot 1)
        do_clear();
        acc(1, 0, 0, 0);
        inv(1, 0);
        acc(5, 0, 0, 0);
        acc(1, 0, 0, 0);
        e = '{3, 0, 1, 0, 0, 0, 0, 0, 0};
        chk_all(e, "R10");

        // R2: mask accumulates several words; refill resets it
        do_clear();
        acc(2, 0, 0, 0);
        acc(2, 2, 1, 0);
        inv(2, 2);
        acc(2, 1, 0, 0);
        acc(2, 0, 1, 0);
        inv(2, 3);
        e = '{2, 1, 1, 0, 0, 1, 0, 1, 0};
        chk_all(e, "R2 mask");

        // R13: same-cycle invalidate+access; access during sync pulse
        do_clear();
        acc(3, 1, 0, 0);
        drive(1, 3, 1, 0, 0, 1, 3, 1, 0, 0);
        e = '{2, 1, 1, 0, 0, 0, 0, 1, 0};
        chk_all(e, "R13 inv first");
        drive(1, 3, 2, 1, 0, 0, 0, 0, 1, 0);
        inv(3, 2);
        e = '{2, 1, 1, 0, 1, 0, 0, 1, 0};
        chk_all(e, "R13 sync same cycle");

        // R11: saturation
        do_clear();
        for (int i = 0; i < 300; i++) acc(7, 0, 0, 0);
        chk(0, 255, "R11 saturate");
        chk(1, 0, "R11 others");

        // R12: clear beats a simultaneous increment
        drive(1, 7, 0, 0, 0, 0, 0, 0, 0, 1);
        chk(0, 0, "R12 clear");
        acc(7, 0, 0, 0);
        chk(0, 1, "R12 after clear");

        // R7: hits never count as misses
        acc(7, 1, 1, 0);
        chk(0, 1, "R7 hit");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule